// File: doc/BRIEF.md
# Address-Sequence Unlock Command Detector

This block sits beside an asynchronous-style SRAM port and watches its access stream for a six-step unlock pattern. The pattern is made of read accesses to fixed addresses. When the last of the six reads completes, the block issues a one-clock request to a separate nonvolatile controller. One final address requests a save of the array contents into nonvolatile storage. The other requests a restore from nonvolatile storage.

The strobes reach the block already synchronised to its clock, and the block samples them once per cycle. An access is counted when chip enable returns high after having been low, so each step is taken as a chip-enable-controlled access ends. Any write access, or any read that is not the expected next address, abandons the attempt. A controller busy flag keeps the detector idle while a request is in service. A supply-good flag blocks save requests while the supply is low.

Top module: `unlock_seq_detect`

## Requirements
- R1: After six completed read accesses to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 (compared on address bits 13:0), `storeReq` is high for the clock cycle that follows the clock edge at which the sixth access is seen to complete.
- R2: The same five leading reads followed by a sixth read of 0x0C63 raise `recallReq` in the same cycle position instead.
- R3: Only address bits 13:0 are compared. Bit 14 has no effect on matching.
- R4: An access completes at the first clock edge where `ceN` is sampled high after it was sampled low on the previous edge. An access held low for several cycles counts as one step, and no step is taken while `ceN` stays low. `oeN` has no effect on detection.
- R5: An access during which `weN` is sampled low on any edge while `ceN` is low is a write. A write aborts the sequence, and the following reads must start again from 0x0E38.
- R6: A read of any address other than the expected next one aborts the sequence. If that read is 0x0E38, it counts as step one of a new attempt.
- R7: If `supplyOk` is low at the edge where a save sequence completes, no `storeReq` is issued and the detector returns to idle. Restore requests are not affected by `supplyOk`.
- R8: While `busy` is high, the detector is held idle. An access that completes while `busy` is high does not advance the sequence.
- R9: A synchronous active-low `rstN` clears a partial sequence and drives both request outputs low.
- R10: Each request lasts exactly one cycle, and `storeReq` and `recallReq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| ceN | input | 1 | Synchronised chip enable, active low |
| weN | input | 1 | Synchronised write enable, active low |
| oeN | input | 1 | Synchronised output enable, active low. Does not affect detection |
| addr | input | 15 | SRAM address bus |
| supplyOk | input | 1 | High when the supply is above the switch threshold |
| busy | input | 1 | Controller is servicing a request |
| storeReq | output | 1 | One-cycle save request |
| recallReq | output | 1 | One-cycle restore request |

## Verification
The bench checks that an aborting read of 0x0E38 restarts the count at step one. A design that only returned to idle would then miss the command that follows. A write pulse in the middle of a long access must abort the sequence, which catches a design that samples `weN` only on the final edge. The bench holds chip enable low across several edges to catch designs that step on the level of `ceN` rather than on the completed access. It sets address bit 14, drives `supplyOk` low on a save, and raises `busy` in mid-sequence. A design that compared the full address, ignored the supply, or kept its step count through `busy` would then issue a request the bench does not expect, or miss one it does.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  localparam int STEPS  = 6;
  localparam int NCODES = STEPS + 1;

  // Strobes from the datapath to the control.
  typedef struct packed {
    logic done;       // an access completed at this edge
    logic isWrite;    // the completed access was a write
    logic hitNext;    // captured address matches the expected step
    logic hitFirst;   // captured address matches the first code
    logic hitStore;   // captured address matches the save final code
    logic hitRecall;  // captured address matches the restore final code
  } evt_t;

  // Entries 0..4 are the shared prefix, 5 is the save final, 6 is the restore final.
  function automatic logic [15:0] codeAt(input int idx);
    case (idx)
      0:       codeAt = 16'h0E38;
      1:       codeAt = 16'h31C7;
      2:       codeAt = 16'h03E0;
      3:       codeAt = 16'h3C1F;
      4:       codeAt = 16'h303F;
      5:       codeAt = 16'h0FC0;
      6:       codeAt = 16'h0C63;
      default: codeAt = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/unlock_datapath.sv
module unlock_datapath
  import unlock_pkg::*;
#(
  parameter int CMP_W  = 14,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [CMP_W-1:0]  addrLo,
  input  logic [STEP_W-1:0] step,
  output evt_t              evt
);

  logic             ceNq;
  logic [CMP_W-1:0] capAddr;
  logic             capWr;
  logic [NCODES-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceNq    <= 1'b1;
      capAddr <= '0;
      capWr   <= 1'b0;
    end else begin
      ceNq <= ceN;
      if (!ceN) begin
        capAddr <= addrLo;
        capWr   <= ceNq ? !weN : (capWr | !weN);
      end
    end
  end

  for (genvar g = 0; g < NCODES; g++) begin : g_cmp
    localparam logic [15:0] CODE = codeAt(g);
    assign hitVec[g] = (capAddr == CODE[CMP_W-1:0]);
  end

  always_comb begin
    evt.done      = !ceNq && ceN;
    evt.isWrite   = capWr;
    evt.hitFirst  = hitVec[0];
    evt.hitStore  = hitVec[STEPS-1];
    evt.hitRecall = hitVec[STEPS];
    evt.hitNext   = 1'b0;
    for (int i = 0; i < STEPS - 1; i++) begin
      if (step == STEP_W'(i)) evt.hitNext = hitVec[i];
    end
  end

endmodule

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  evt_t              evt,
  input  logic              supplyOk,
  input  logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              storeReq,
  output logic              recallReq
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);
  localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step      <= '0;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
      if (busy) begin
        step <= '0;
      end else if (evt.done) begin
        if (evt.isWrite) begin
          step <= '0;
        end else if (step == LAST) begin
          storeReq  <= evt.hitStore && supplyOk;
          recallReq <= evt.hitRecall;
          step      <= evt.hitFirst ? ONE : '0;
        end else if (evt.hitNext) begin
          step <= step + ONE;
        end else begin
          step <= evt.hitFirst ? ONE : '0;
        end
      end
    end
  end

endmodule

// File: rtl/unlock_seq_detect.sv
module unlock_seq_detect
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CMP_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              supplyOk,
  input  logic              busy,
  output logic              storeReq,
  output logic              recallReq
);

  localparam int STEP_W = $clog2(STEPS);

  evt_t              evt;
  logic [STEP_W-1:0] step;

  unlock_datapath #(.CMP_W(CMP_W), .STEP_W(STEP_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ceN    (ceN),
    .weN    (weN),
    .addrLo (addr[CMP_W-1:0]),
    .step   (step),
    .evt    (evt)
  );

  unlock_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .supplyOk  (supplyOk),
    .busy      (busy),
    .step      (step),
    .storeReq  (storeReq),
    .recallReq (recallReq)
  );

endmodule

// File: rtl/unlock_seq_detect_chk.sv
module unlock_seq_detect_chk #(
  parameter int ADDR_W = 15,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              weN,
  input logic              oeN,
  input logic [ADDR_W-1:0] addr,
  input logic              supplyOk,
  input logic              busy,
  input logic              storeReq,
  input logic              recallReq,
  input logic [STEP_W-1:0] step
);

  // R10
  excl_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));

  // R10
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  // R10
  recall_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

  // R7
  store_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> $past(supplyOk));

  // R8
  busy_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (step == '0 && !storeReq && !recallReq));

  // R4
  req_on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> ($past(ceN) && !$past(ceN, 2)));

  // R5
  req_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> $past(weN, 2));

  // R4
  known_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({oeN, addr, ceN, weN}));

endmodule

bind unlock_seq_detect unlock_seq_detect_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ceN       (ceN),
  .weN       (weN),
  .oeN       (oeN),
  .addr      (addr),
  .supplyOk  (supplyOk),
  .busy      (busy),
  .storeReq  (storeReq),
  .recallReq (recallReq),
  .step      (step)
);

// File: tb/test_unlock_seq_detect.sv
module test_unlock_seq_detect;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1;
  logic        weN = 1'b1;
  logic        oeN = 1'b0;
  logic [14:0] addr = '0;
  logic        supplyOk = 1'b1;
  logic        busy = 1'b0;
  logic        storeReq;
  logic        recallReq;

  int checks = 0;
  int errors = 0;

  localparam logic [14:0] PFX0 = 15'h0E38;
  localparam logic [14:0] PFX1 = 15'h31C7;
  localparam logic [14:0] PFX2 = 15'h03E0;
  localparam logic [14:0] PFX3 = 15'h3C1F;
  localparam logic [14:0] PFX4 = 15'h303F;
  localparam logic [14:0] SAVE = 15'h0FC0;
  localparam logic [14:0] REST = 15'h0C63;

  always #4 clk = ~clk;

  unlock_seq_detect i_unlock_seq_detect (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .supplyOk(supplyOk), .busy(busy), .storeReq(storeReq), .recallReq(recallReq)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {store,recall} actual %b expected %b", req, act, exp);
    end
  endtask

  // One access: ceN low for 'hold' edges, weN low on the first of them if wr.
  task automatic access(input logic [14:0] a, input logic wr, input int hold,
                        output logic [1:0] res);
    @(negedge clk);
    ceN = 1'b0; addr = a; weN = !wr;
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      weN = 1'b1;
    end
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
    res = {storeReq, recallReq};
  endtask

  task automatic rd(input logic [14:0] a, output logic [1:0] res);
    access(a, 1'b0, 1, res);
  endtask

  task automatic prefix(input logic [14:0] hi);
    logic [1:0] r;
    rd(PFX0 | hi, r); rd(PFX1 | hi, r); rd(PFX2 | hi, r);
    rd(PFX3 | hi, r); rd(PFX4 | hi, r);
  endtask

  task automatic idleChk(input string req);
    @(negedge clk);
    chk(req, {storeReq, recallReq}, 2'b00);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R9 reset state", {storeReq, recallReq}, 2'b00);
    rstN = 1'b1;
  endtask

  task automatic t_store;
    logic [1:0] r;
    prefix(15'h0);
    rd(SAVE, r);
    chk("R1 save command", r, 2'b10);
    idleChk("R10 save pulse one cycle");
  endtask

  task automatic t_recall_oe;
    logic [1:0] r;
    oeN = 1'b1;
    prefix(15'h0);
    rd(REST, r);
    chk("R2 restore command with oeN high (R4)", r, 2'b01);
    idleChk("R10 restore pulse one cycle");
    oeN = 1'b0;
  endtask

  task automatic t_bit14;
    logic [1:0] r;
    prefix(15'h4000);
    rd(SAVE | 15'h4000, r);
    chk("R3 bit 14 ignored", r, 2'b10);
  endtask

  task automatic t_write_abort;
    logic [1:0] r;
    rd(PFX0, r); rd(PFX1, r);
    access(PFX2, 1'b1, 1, r);
    rd(PFX3, r); rd(PFX4, r); rd(SAVE, r);
    chk("R5 write aborts", r, 2'b00);
    // write pulse in the middle of a long access
    rd(PFX0, r); rd(PFX1, r);
    @(negedge clk); ceN = 1'b0; addr = PFX2;
    @(negedge clk); weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
    @(negedge clk);
    rd(PFX3, r); rd(PFX4, r); rd(SAVE, r);
    chk("R5 mid-access write aborts", r, 2'b00);
    prefix(15'h0); rd(REST, r);
    chk("R5 clean retry after write", r, 2'b01);
  endtask

  task automatic t_wrong_addr;
    logic [1:0] r;
    rd(PFX0, r); rd(PFX1, r); rd(15'h1234, r);
    rd(PFX3, r); rd(PFX4, r); rd(SAVE, r);
    chk("R6 wrong address aborts", r, 2'b00);
    rd(PFX0, r); rd(PFX1, r); rd(PFX2, r);
    rd(PFX0, r);   // abort that restarts at step one
    rd(PFX1, r); rd(PFX2, r); rd(PFX3, r); rd(PFX4, r); rd(SAVE, r);
    chk("R6 aborting first code restarts", r, 2'b10);
    prefix(15'h0); rd(PFX0, r);
    chk("R6 first code at step six no request", r, 2'b00);
  endtask

  task automatic t_supply;
    logic [1:0] r;
    prefix(15'h0);
    supplyOk = 1'b0;
    rd(SAVE, r);
    chk("R7 save blocked on low supply", r, 2'b00);
    prefix(15'h0); rd(REST, r);
    chk("R7 restore allowed on low supply", r, 2'b01);
    supplyOk = 1'b1;
    rd(SAVE, r);
    chk("R7 detector idle after blocked save", r, 2'b00);
  endtask

  task automatic t_busy;
    logic [1:0] r;
    rd(PFX0, r); rd(PFX1, r);
    busy = 1'b1;
    rd(PFX2, r);
    busy = 1'b0;
    rd(PFX3, r); rd(PFX4, r); rd(SAVE, r);
    chk("R8 busy clears sequence", r, 2'b00);
    prefix(15'h0);
    busy = 1'b1;
    rd(REST, r);
    busy = 1'b0;
    chk("R8 final step ignored while busy", r, 2'b00);
  endtask

  task automatic t_reset_mid;
    logic [1:0] r;
    prefix(15'h0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(SAVE, r);
    chk("R9 reset clears partial sequence", r, 2'b00);
  endtask

  task automatic t_long_hold;
    logic [1:0] r;
    rd(PFX0, r);
    access(PFX1, 1'b0, 4, r);
    rd(PFX2, r); rd(PFX3, r); rd(PFX4, r);
    @(negedge clk); ceN = 1'b0; addr = SAVE;
    repeat (4) @(negedge clk);
    chk("R4 no step while ceN held low", {storeReq, recallReq}, 2'b00);
    ceN = 1'b1;
    @(negedge clk);
    chk("R4 step on release after long hold", {storeReq, recallReq}, 2'b10);
  endtask

  initial begin
    t_reset();
    t_store();
    t_recall_oe();
    t_bit14();
    t_write_abort();
    t_wrong_addr();
    t_supply();
    t_busy();
    t_reset_mid();
    t_long_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule